// File: doc/BRIEF.md
# Five-Stage In-Order Pipeline Sequencer with Interrupt Flush

This block is the sequencing skeleton of an in-order instruction pipeline with five stages: fetch, decode, operand fetch, execute and writeback. Each stage register holds a valid flag, the instruction word and the program counter of that instruction. While fetching is enabled, a new word is read from a simple fetch port every cycle. Every occupied stage moves forward by one stage per clock. The instruction in writeback is reported as retired. A free-running cycle counter lets the surrounding logic or a testbench measure how long a stream of instructions takes to drain.

An external interrupt request is sampled on the rising edge. When it is accepted, the instruction in writeback completes and the four younger stages are emptied. One cycle later the block raises a single-cycle handler entry pulse and presents the address at which the program continues. Fetching stays suspended while the handler runs. A single-cycle return input reloads the fetch counter with the saved address, and the flushed instructions are then fetched again.

Top module: `pipe5_irq_top`

## Requirements
- R1: An instruction captured into the fetch stage at clock edge e is in writeback, and shows on retire_valid, retire_pc and retire_insn, in the cycle that follows edge e+4, unless an interrupt is accepted in between.
- R2: While fetch_en is high, no handler is active and no interrupt is being accepted, the word on insn_in is captured at every edge together with fetch_pc, and fetch_pc then increments by one.
- R3: A stream of N consecutive instructions fetched with no interruption retires completely in N+4 cycles. The count starts with the cycle in which the first instruction is in fetch and ends with the cycle in which the last one is in writeback.
- R4: A synchronous active-high reset empties every stage and clears the handler flag, the entry pulse and cycle_count. It also sets fetch_pc to zero.
- R5: An interrupt is accepted at an edge where irq_req is high and handler_active is low. The instruction in writeback retires at that edge. The instructions in fetch, decode, operand fetch and execute are discarded and never retire, and retire_valid is low in the following cycle.
- R6: handler_entry is high for exactly one cycle, the cycle after the accepting edge. handler_active goes high in that same cycle and stays high until a return.
- R7: If writeback holds a valid instruction at acceptance, resume_pc becomes the program counter of that instruction plus one.
- R8: If writeback is empty at acceptance, resume_pc becomes the program counter of the oldest valid instruction in the other four stages. If every stage is empty, resume_pc becomes fetch_pc.
- R9: While handler_active is high, no instruction is fetched, fetch_pc holds, and irq_req is ignored: resume_pc holds and no further entry pulse is raised.
- R10: irq_return held high for one cycle while the handler is active loads fetch_pc with resume_pc and clears handler_active at that edge. Retirement then continues from resume_pc with no gap and no repeated address.
- R11: cycle_count increases by one on every clock edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Allows a new instruction to enter fetch each cycle |
| insn_in | input | INSN_W (32) | Instruction word located at fetch_pc |
| fetch_pc | output | PC_W (16) | Address of the next instruction to fetch |
| irq_req | input | 1 | Interrupt request, sampled on the rising edge |
| irq_return | input | 1 | One-cycle return from the handler |
| handler_entry | output | 1 | One-cycle pulse after an interrupt is accepted |
| handler_active | output | 1 | High while the handler runs |
| resume_pc | output | PC_W (16) | Address at which execution continues after return |
| retire_valid | output | 1 | An instruction is in writeback and retires this cycle |
| retire_pc | output | PC_W (16) | Program counter of the retiring instruction |
| retire_insn | output | INSN_W (32) | Word of the retiring instruction |
| cycle_count | output | CNT_W (32) | Free-running cycle counter |

## Verification
The assertions watch the per-cycle rules on every cycle:
- an instruction in execute reaches writeback at the next edge;
- acceptance leaves writeback empty and starts the handler with a single entry pulse;
- a handler blocks fetching and freezes resume_pc;
- a return reloads the fetch counter;
- fetch_pc steps by one while fetching.

Some properties span a whole episode, and only the bench scenarios can show them: the N+4 drain length over whole streams, the exact resume address chosen among the three fallback cases, and the fact that the flushed instructions retire exactly once, after the return, in unbroken address order.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int PC_W   = 16;
    localparam int INSN_W = 32;
    localparam int NSTAGE = 5;
    localparam int CNT_W  = 32;
    localparam int WB_IDX = NSTAGE - 1;
    localparam int EX_IDX = NSTAGE - 2;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_DECODE = 3'd1,
        ST_OPER = 3'd2,
        ST_EXEC = 3'd3,
        ST_WBACK = 3'd4
    } stage_e;

    typedef struct packed {
        logic              valid;
        logic [PC_W-1:0]   pc;
        logic [INSN_W-1:0] insn;
    } stage_t;

    function automatic stage_t empty_slot();
        stage_t s;
        s.valid = 1'b0;
        s.pc    = '0;
        s.insn  = '0;
        return s;
    endfunction

endpackage

// File: rtl/pipe5_fetch.sv
module pipe5_fetch
    import pipe5_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_go,
    input  logic              pc_load,
    input  logic [PC_W-1:0]   pc_load_val,
    input  logic [INSN_W-1:0] insn_in,
    output logic [PC_W-1:0]   fetch_pc,
    output stage_t            s_fetch
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pc <= '0;
            s_fetch  <= empty_slot();
        end else begin
            if (pc_load)
                fetch_pc <= pc_load_val;
            else if (fetch_go)
                fetch_pc <= fetch_pc + PC_W'(1);
            s_fetch.valid <= fetch_go;
            s_fetch.pc    <= fetch_pc;
            s_fetch.insn  <= insn_in;
        end
    end

endmodule

// File: rtl/pipe5_stage_reg.sv
module pipe5_stage_reg
    import pipe5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  stage_t d,
    output stage_t q
);

    always_ff @(posedge clk) begin
        if (rst || flush)
            q <= empty_slot();
        else
            q <= d;
    end

endmodule

// File: rtl/pipe5_irq_ctl.sv
module pipe5_irq_ctl
    import pipe5_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_req,
    input  logic            irq_return,
    input  stage_t          stg [NSTAGE],
    input  logic [PC_W-1:0] fetch_pc,
    output logic            irq_accept,
    output logic            pc_load,
    output logic            handler_active,
    output logic            handler_entry,
    output logic [PC_W-1:0] resume_pc
);

    logic [PC_W-1:0] resume_next;

    assign irq_accept = irq_req & ~handler_active;
    assign pc_load    = irq_return & handler_active;

    // Later (older) stages overwrite earlier ones; writeback wins outright.
    always_comb begin
        resume_next = fetch_pc;
        for (int k = 0; k < WB_IDX; k++) begin
            if (stg[k].valid)
                resume_next = stg[k].pc;
        end
        if (stg[WB_IDX].valid)
            resume_next = stg[WB_IDX].pc + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            handler_active <= 1'b0;
            handler_entry  <= 1'b0;
            resume_pc      <= '0;
        end else begin
            handler_entry <= irq_accept;
            if (irq_accept) begin
                handler_active <= 1'b1;
                resume_pc      <= resume_next;
            end else if (pc_load) begin
                handler_active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pipe5_irq_top.sv
module pipe5_irq_top
    import pipe5_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [INSN_W-1:0] insn_in,
    output logic [PC_W-1:0]   fetch_pc,
    input  logic              irq_req,
    input  logic              irq_return,
    output logic              handler_entry,
    output logic              handler_active,
    output logic [PC_W-1:0]   resume_pc,
    output logic              retire_valid,
    output logic [PC_W-1:0]   retire_pc,
    output logic [INSN_W-1:0] retire_insn,
    output logic [CNT_W-1:0]  cycle_count
);

    stage_t stg [NSTAGE];
    logic   irq_accept;
    logic   pc_load;
    logic   fetch_go;

    assign fetch_go = fetch_en & ~handler_active & ~irq_accept;

    pipe5_fetch u_fetch (
        .clk         (clk),
        .rst         (rst),
        .fetch_go    (fetch_go),
        .pc_load     (pc_load),
        .pc_load_val (resume_pc),
        .insn_in     (insn_in),
        .fetch_pc    (fetch_pc),
        .s_fetch     (stg[0])
    );

    for (genvar g = 1; g < NSTAGE; g++) begin : g_stage
        pipe5_stage_reg u_stage (
            .clk   (clk),
            .rst   (rst),
            .flush (irq_accept),
            .d     (stg[g-1]),
            .q     (stg[g])
        );
    end

    pipe5_irq_ctl u_ctl (
        .clk            (clk),
        .rst            (rst),
        .irq_req        (irq_req),
        .irq_return     (irq_return),
        .stg            (stg),
        .fetch_pc       (fetch_pc),
        .irq_accept     (irq_accept),
        .pc_load        (pc_load),
        .handler_active (handler_active),
        .handler_entry  (handler_entry),
        .resume_pc      (resume_pc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cycle_count <= '0;
        else
            cycle_count <= cycle_count + CNT_W'(1);
    end

    assign retire_valid = stg[WB_IDX].valid;
    assign retire_pc    = stg[WB_IDX].pc;
    assign retire_insn  = stg[WB_IDX].insn;

endmodule

// File: rtl/pipe5_irq_chk.sv
module pipe5_irq_chk
    import pipe5_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            fetch_en,
    input logic            irq_req,
    input logic            irq_return,
    input logic            handler_active,
    input logic            handler_entry,
    input logic [PC_W-1:0] resume_pc,
    input logic [PC_W-1:0] fetch_pc,
    input logic            retire_valid,
    input logic [PC_W-1:0] retire_pc,
    input logic            ex_valid,
    input logic [PC_W-1:0] ex_pc,
    input logic            if_valid
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!handler_active && !handler_entry && fetch_pc == '0 && !retire_valid)); // R4

    AST_EX_TO_WB: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !(irq_req && !handler_active)) |=> (retire_valid && retire_pc == $past(ex_pc))); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (fetch_en && !handler_active && !irq_req) |=> (fetch_pc == PC_W'($past(fetch_pc) + 1'b1))); // R2

    AST_FLUSH_WB: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !handler_active) |=> !retire_valid); // R5

    AST_ENTRY_START: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !handler_active) |=> (handler_entry && handler_active)); // R6

    AST_ENTRY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        handler_entry |=> !handler_entry); // R6

    AST_NO_FETCH_IN_HANDLER: assert property (@(posedge clk) disable iff (rst)
        handler_active |=> !if_valid); // R9

    AST_RESUME_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (handler_active && !irq_return) |=> ($stable(resume_pc) && handler_active && $stable(fetch_pc))); // R9

    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (handler_active && irq_return) |=> (!handler_active && fetch_pc == $past(resume_pc))); // R10

endmodule

bind pipe5_irq_top pipe5_irq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .fetch_en       (fetch_en),
    .irq_req        (irq_req),
    .irq_return     (irq_return),
    .handler_active (handler_active),
    .handler_entry  (handler_entry),
    .resume_pc      (resume_pc),
    .fetch_pc       (fetch_pc),
    .retire_valid   (retire_valid),
    .retire_pc      (retire_pc),
    .ex_valid       (stg[pipe5_pkg::EX_IDX].valid),
    .ex_pc          (stg[pipe5_pkg::EX_IDX].pc),
    .if_valid       (stg[0].valid)
);

// File: tb/test_pipe5_irq_top.sv
module test_pipe5_irq_top;
    import pipe5_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fetch_en = 1'b0;
    logic              irq_req = 1'b0;
    logic              irq_return = 1'b0;
    logic [INSN_W-1:0] insn_in;
    logic [PC_W-1:0]   fetch_pc;
    logic              handler_entry;
    logic              handler_active;
    logic [PC_W-1:0]   resume_pc;
    logic              retire_valid;
    logic [PC_W-1:0]   retire_pc;
    logic [INSN_W-1:0] retire_insn;
    logic [CNT_W-1:0]  cycle_count;

    int  n_chk = 0;
    int  n_fail = 0;
    int  exp_ret = 0;
    int  n_ret = 0;
    int  first_ret_cnt = 0;
    int  last_ret_cnt = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [INSN_W-1:0] mem_word(logic [PC_W-1:0] p);
        return INSN_W'(32'hC0DE_0000) ^ INSN_W'(p);
    endfunction

    assign insn_in = mem_word(fetch_pc);

    pipe5_irq_top i_pipe5_irq_top (
        .clk            (clk),
        .rst            (rst),
        .fetch_en       (fetch_en),
        .insn_in        (insn_in),
        .fetch_pc       (fetch_pc),
        .irq_req        (irq_req),
        .irq_return     (irq_return),
        .handler_entry  (handler_entry),
        .handler_active (handler_active),
        .resume_pc      (resume_pc),
        .retire_valid   (retire_valid),
        .retire_pc      (retire_pc),
        .retire_insn    (retire_insn),
        .cycle_count    (cycle_count)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock; sample 1 ns after the edge and log any retirement (R1, R10 ordering)
    task automatic step();
        @(posedge clk);
        #1;
        if (retire_valid) begin
            check("R1", "retire_pc in order", retire_pc, exp_ret);
            check("R1", "retire_insn matches word", retire_insn, mem_word(retire_pc));
            if (n_ret == 0) first_ret_cnt = int'(cycle_count);
            last_ret_cnt = int'(cycle_count);
            exp_ret++;
            n_ret++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; fetch_en = 1'b0; irq_req = 1'b0; irq_return = 1'b0;
        step();
        step();
        rst = 1'b0;
        exp_ret = 0; n_ret = 0; first_ret_cnt = 0; last_ret_cnt = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R4", "fetch_pc after reset", fetch_pc, 0);
        check("R4", "handler_active after reset", handler_active, 0);
        check("R4", "handler_entry after reset", handler_entry, 0);
        check("R4", "retire_valid after reset", retire_valid, 0);
        check("R4", "cycle_count after reset", cycle_count, 0);
        step();
        check("R11", "cycle_count +1", cycle_count, 1);
        step();
        check("R11", "cycle_count +2", cycle_count, 2);
    endtask

    task automatic t_stream(int n);
        do_reset();
        fetch_en = 1'b1;
        step();                                // first fetch at the edge that brings cycle_count to 1
        check("R2", "fetch_pc after first fetch", fetch_pc, 1);
        for (int i = 1; i < n; i++) step();
        fetch_en = 1'b0;
        check("R2", "fetch_pc after stream", fetch_pc, n);
        for (int i = 0; i < 12; i++) step();
        check("R3", "instructions retired", n_ret, n);
        check("R1", "first retire cycle", first_ret_cnt, 5);
        check("R3", "cycles to drain stream", last_ret_cnt, n + 4);
        check("R11", "cycle_count after run", cycle_count, n + 12);
    endtask

    task automatic t_irq(int fsteps, int idle, int exp_resume, string req);
        logic [PC_W-1:0] held_pc;
        do_reset();
        fetch_en = 1'b1;
        for (int i = 0; i < fsteps; i++) step();
        if (idle > 0) begin
            fetch_en = 1'b0;
            for (int i = 0; i < idle; i++) step();
            fetch_en = 1'b1;
        end
        irq_req = 1'b1;
        step();                                // accepting edge
        check("R6", "handler_entry after accept", handler_entry, 1);
        check("R6", "handler_active after accept", handler_active, 1);
        check("R5", "retire_valid after accept", retire_valid, 0);
        check(req, "resume_pc", resume_pc, exp_resume);
        step();                                // irq_req still high: must be ignored
        check("R6", "handler_entry second cycle", handler_entry, 0);
        check("R9", "resume_pc held", resume_pc, exp_resume);
        held_pc = fetch_pc;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R5", "no retire while flushed", retire_valid, 0);
            check("R9", "fetch_pc frozen", fetch_pc, held_pc);
            check("R9", "no repeated entry", handler_entry, 0);
        end
        irq_req = 1'b0;
        irq_return = 1'b1;
        step();
        irq_return = 1'b0;
        check("R10", "handler_active after return", handler_active, 0);
        check("R10", "fetch_pc reloaded", fetch_pc, exp_resume);
        for (int i = 0; i < 12; i++) step();
        check("R10", "resumed stream retired past resume_pc", (exp_ret > exp_resume) ? 1 : 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stream(6);
        t_stream(1);
        t_stream(9);
        t_irq(7, 0, 3, "R7");   // writeback holds pc 2
        t_irq(9, 0, 5, "R7");   // writeback holds pc 4
        t_irq(2, 0, 0, "R8");   // only fetch/decode occupied, oldest is pc 0
        t_irq(4, 0, 0, "R8");   // writeback empty, execute holds pc 0
        t_irq(3, 8, 3, "R8");   // fully drained, resume from fetch_pc
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule